// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Predecode Unit

This block fetches one instruction per request from a small byte-addressed instruction store and splits it into its fields. Instructions are one to six bytes long. The first byte carries an operation code and a function code. Depending on the operation, a byte with two register specifiers may follow, then a 32-bit constant, or both. The unit reads a six-byte window starting at the requested address into registers. From that window it works out the instruction length, the register and constant fields, the address of the next sequential instruction, and a two-bit status.

A later stage drives `fetch_req` together with `fetch_pc` and uses the result one cycle later. The store is filled through a plain byte-wide write port. In a system this port is driven by whatever loads the program; in the bench it is used for preloading.

Top module: `ifu_fetch`

## Requirements
- R1: A result appears on the outputs, with `out_valid` high, in the cycle after a clock edge that samples `fetch_req` high. `out_valid` is low after reset and in any cycle that follows an edge with `fetch_req` low.
- R2: `icode` is bits 7:4 of the byte at `fetch_pc`, and `ifun` is bits 3:0 of that byte.
- R3: Opcodes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB carry a register byte at `fetch_pc+1`. For these, `reg_a` is bits 7:4 of that byte and `reg_b` is bits 3:0. For every other opcode, both outputs are 0xF.
- R4: Opcodes 0x3, 0x4 and 0x5 carry a constant in bytes `pc+2..pc+5`, and opcodes 0x7 and 0x8 carry one in bytes `pc+1..pc+4`. The constant is assembled with the lowest address as the least significant byte. For all other opcodes, `const_val` is 0.
- R5: `next_pc` equals `fetch_pc + 1`, plus 1 if a register byte is present, plus 4 if a constant is present.
- R6: `status` is encoded as 0 for normal, 1 for halt, 2 for bad address and 3 for illegal instruction. The byte 0x00 (halt) gives status 1.
- R7: These pairs give status 3: any opcode above 0xB; opcode 0x2 or 0x7 with a function above 6; opcode 0x6 with a function above 3; any other opcode with a non-zero function.
- R8: If any byte of the instruction lies at an address of `MEM_BYTES` or above, the status is 2. This takes priority over illegal and halt. An instruction that ends exactly at the last byte is in range.
- R9: With `ld_en` high at a clock edge, `ld_data` is written to byte `ld_addr`. A later fetch returns the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Store write enable |
| ld_addr | input | $clog2(MEM_BYTES) | Store write byte address |
| ld_data | input | 8 | Store write byte |
| fetch_req | input | 1 | Fetch request |
| fetch_pc | input | 32 | Address of the instruction to fetch |
| out_valid | output | 1 | Result valid |
| icode | output | 4 | Operation code |
| ifun | output | 4 | Function code |
| reg_a | output | 4 | First register specifier, 0xF if absent |
| reg_b | output | 4 | Second register specifier, 0xF if absent |
| const_val | output | 32 | Constant word, 0 if absent |
| next_pc | output | 32 | Address of the next sequential instruction |
| status | output | 2 | 0 normal, 1 halt, 2 bad address, 3 illegal |

## Verification
Every decoded output is due exactly one clock edge after the edge that samples the request: the byte window and the address are registered once, and all decoding after that register is combinational. Each bench task raises the request on a falling edge and waits for one rising edge. It drops the request on the next falling edge and samples every output at that same falling edge, half a period after the outputs settled. The idle check samples one cycle later to confirm that `out_valid` falls again.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 32;
  localparam int WIN_BYTES = 6;
  localparam int WIN_W     = WIN_BYTES * BYTE_W;
  localparam int LEN_W     = 3;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_RRMOV = 4'h2;
  localparam logic [3:0] OP_IRMOV = 4'h3;
  localparam logic [3:0] OP_RMMOV = 4'h4;
  localparam logic [3:0] OP_MRMOV = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

  localparam logic [3:0] NO_REG = 4'hF;

  typedef enum logic [1:0] {
    ST_OK  = 2'd0,
    ST_HLT = 2'd1,
    ST_ADR = 2'd2,
    ST_INS = 2'd3
  } stat_e;

  function automatic logic op_has_reg(input logic [3:0] op);
    case (op)
      OP_RRMOV, OP_IRMOV, OP_RMMOV, OP_MRMOV,
      OP_ALU, OP_PUSH, OP_POP: op_has_reg = 1'b1;
      default:                 op_has_reg = 1'b0;
    endcase
  endfunction

  function automatic logic op_has_const(input logic [3:0] op);
    case (op)
      OP_IRMOV, OP_RMMOV, OP_MRMOV, OP_JUMP, OP_CALL: op_has_const = 1'b1;
      default:                                        op_has_const = 1'b0;
    endcase
  endfunction

  function automatic logic pair_legal(input logic [3:0] op, input logic [3:0] fn);
    case (op)
      OP_RRMOV, OP_JUMP: pair_legal = (fn <= 4'd6);
      OP_ALU:            pair_legal = (fn <= 4'd3);
      OP_HALT, OP_NOP, OP_IRMOV, OP_RMMOV, OP_MRMOV,
      OP_CALL, OP_RET, OP_PUSH, OP_POP:
                         pair_legal = (fn == 4'd0);
      default:           pair_legal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ifu_imem.sv
module ifu_imem
  import ifu_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int IDX_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [WORD_W-1:0] rd_addr,
  output logic [WIN_W-1:0]  rd_window
);

  localparam logic [WORD_W:0] LIMIT = (WORD_W+1)'(MEM_BYTES);

  logic [BYTE_W-1:0] mem_q [MEM_BYTES];

  // write port: one byte per edge
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  // one read lane per window byte; bytes past the end read as zero
  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_lane
    logic [WORD_W:0]   lane_addr;
    logic              lane_in;
    logic [IDX_W-1:0]  lane_idx;
    logic [BYTE_W-1:0] lane_d;
    logic [BYTE_W-1:0] lane_q;

    always_comb begin
      lane_addr = {1'b0, rd_addr} + (WORD_W+1)'(k);
      lane_in   = (lane_addr < LIMIT);
      lane_idx  = lane_addr[IDX_W-1:0];
      lane_d    = lane_in ? mem_q[lane_idx] : '0;
    end

    always_ff @(posedge clk) begin
      if (rd_en) begin
        lane_q <= lane_d;
      end
    end

    assign rd_window[k*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/ifu_predecode.sv
module ifu_predecode
  import ifu_pkg::*;
(
  input  logic [WIN_W-1:0]  window,
  output logic [3:0]        op,
  output logic [3:0]        fn,
  output logic [3:0]        ra,
  output logic [3:0]        rb,
  output logic [WORD_W-1:0] cval,
  output logic [LEN_W-1:0]  len,
  output logic              legal,
  output logic              halt
);

  logic [BYTE_W-1:0] b [WIN_BYTES];
  logic              has_reg;
  logic              has_const;

  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_split
    assign b[k] = window[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    op        = b[0][7:4];
    fn        = b[0][3:0];
    has_reg   = op_has_reg(op);
    has_const = op_has_const(op);
    legal     = pair_legal(op, fn);
    halt      = (op == OP_HALT);

    ra = NO_REG;
    rb = NO_REG;
    if (has_reg) begin
      ra = b[1][7:4];
      rb = b[1][3:0];
    end

    cval = '0;
    if (has_const) begin
      if (has_reg) cval = {b[5], b[4], b[3], b[2]};
      else         cval = {b[4], b[3], b[2], b[1]};
    end

    len = LEN_W'(1) + (has_reg ? LEN_W'(1) : LEN_W'(0))
                    + (has_const ? LEN_W'(4) : LEN_W'(0));
  end

endmodule

// File: rtl/ifu_seqpc.sv
module ifu_seqpc
  import ifu_pkg::*;
#(
  parameter int MEM_BYTES = 256
) (
  input  logic [WORD_W-1:0] pc,
  input  logic [LEN_W-1:0]  len,
  output logic [WORD_W-1:0] npc,
  output logic              addr_fault
);

  localparam logic [WORD_W:0] LIMIT = (WORD_W+1)'(MEM_BYTES);

  logic [WORD_W:0] end_addr;

  always_comb begin
    end_addr   = {1'b0, pc} + (WORD_W+1)'(len);
    npc        = end_addr[WORD_W-1:0];
    addr_fault = ({1'b0, pc} >= LIMIT) || (end_addr > LIMIT);
  end

endmodule

// File: rtl/ifu_fetch.sv
module ifu_fetch
  import ifu_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int IDX_W    = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_addr,
  input  logic [7:0]       ld_data,
  input  logic             fetch_req,
  input  logic [31:0]      fetch_pc,
  output logic             out_valid,
  output logic [3:0]       icode,
  output logic [3:0]       ifun,
  output logic [3:0]       reg_a,
  output logic [3:0]       reg_b,
  output logic [31:0]      const_val,
  output logic [31:0]      next_pc,
  output logic [1:0]       status
);

  logic [WIN_W-1:0]  window;
  logic              valid_d, valid_q;
  logic [WORD_W-1:0] pc_d, pc_q;
  logic [LEN_W-1:0]  ilen;
  logic              legal, halt, addr_fault;
  stat_e             stat_c;

  ifu_imem #(.MEM_BYTES(MEM_BYTES)) u_imem (
    .clk      (clk),
    .wr_en    (ld_en),
    .wr_addr  (ld_addr),
    .wr_data  (ld_data),
    .rd_en    (fetch_req),
    .rd_addr  (fetch_pc),
    .rd_window(window)
  );

  // next state
  always_comb begin
    valid_d = fetch_req;
    pc_d    = fetch_req ? fetch_pc : pc_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
    end else begin
      valid_q <= valid_d;
      pc_q    <= pc_d;
    end
  end

  ifu_predecode u_dec (
    .window(window),
    .op    (icode),
    .fn    (ifun),
    .ra    (reg_a),
    .rb    (reg_b),
    .cval  (const_val),
    .len   (ilen),
    .legal (legal),
    .halt  (halt)
  );

  ifu_seqpc #(.MEM_BYTES(MEM_BYTES)) u_seq (
    .pc        (pc_q),
    .len       (ilen),
    .npc       (next_pc),
    .addr_fault(addr_fault)
  );

  // status priority: address fault, then illegal pair, then halt
  always_comb begin
    if (addr_fault)  stat_c = ST_ADR;
    else if (!legal) stat_c = ST_INS;
    else if (halt)   stat_c = ST_HLT;
    else             stat_c = ST_OK;
  end

  assign status    = stat_c;
  assign out_valid = valid_q;

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> out_valid); // R1

  AST_SHORT_HAS_NO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (next_pc == pc_q + 32'd1) |->
      (reg_a == NO_REG) && (reg_b == NO_REG) && (const_val == '0)); // R3

  AST_GOOD_ENDS_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (status != ST_ADR) |-> ({1'b0, next_pc} <= 33'(MEM_BYTES))); // R8

  AST_HALT_ONLY_OPCODE0: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (status == ST_HLT) |-> (icode == OP_HALT) && (ifun == 4'h0)); // R6

endmodule

// File: tb/test_ifu_fetch.sv
`timescale 1ns/1ps
module test_ifu_fetch;

  localparam int MEM_BYTES = 256;
  localparam int IDX_W     = $clog2(MEM_BYTES);

  logic             clk;
  logic             rst_n;
  logic             ld_en;
  logic [IDX_W-1:0] ld_addr;
  logic [7:0]       ld_data;
  logic             fetch_req;
  logic [31:0]      fetch_pc;
  logic             out_valid;
  logic [3:0]       icode, ifun, reg_a, reg_b;
  logic [31:0]      const_val, next_pc;
  logic [1:0]       status;

  int n_chk;
  int n_err;
  bit done;

  ifu_fetch #(.MEM_BYTES(MEM_BYTES)) i_ifu_fetch (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .fetch_req(fetch_req), .fetch_pc(fetch_pc),
    .out_valid(out_valid), .icode(icode), .ifun(ifun),
    .reg_a(reg_a), .reg_b(reg_b), .const_val(const_val),
    .next_pc(next_pc), .status(status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic put(input int addr, input logic [7:0] data);
    @(negedge clk);
    ld_en   = 1'b1;
    ld_addr = IDX_W'(addr);
    ld_data = data;
    @(negedge clk);
    ld_en   = 1'b0;
  endtask

  // request at a falling edge, result due after the next rising edge
  task automatic fetch(input logic [31:0] pc);
    @(negedge clk);
    fetch_req = 1'b1;
    fetch_pc  = pc;
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  task automatic expect_all(input string tag, input logic [31:0] pc,
                            input logic [3:0] e_op, input logic [3:0] e_fn,
                            input logic [3:0] e_ra, input logic [3:0] e_rb,
                            input logic [31:0] e_c, input logic [31:0] e_np,
                            input logic [1:0] e_st);
    fetch(pc);
    chk({tag, " R1"}, "out_valid", 32'(out_valid), 32'd1);
    chk({tag, " R2"}, "icode", 32'(icode), 32'(e_op));
    chk({tag, " R2"}, "ifun", 32'(ifun), 32'(e_fn));
    chk({tag, " R3"}, "reg_a", 32'(reg_a), 32'(e_ra));
    chk({tag, " R3"}, "reg_b", 32'(reg_b), 32'(e_rb));
    chk({tag, " R4"}, "const_val", const_val, e_c);
    chk({tag, " R5"}, "next_pc", next_pc, e_np);
    chk({tag, " R6"}, "status", 32'(status), 32'(e_st));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset", "out_valid", 32'(out_valid), 32'd0);
  endtask

  task automatic t_preload;
    // program image, filled through the load port (R9)
    logic [7:0] img [39] = '{
      8'h00, 8'h10, 8'h20, 8'h12, 8'h25, 8'hAB,
      8'h30, 8'hF3, 8'h78, 8'h56, 8'h34, 8'h12,
      8'h40, 8'h15, 8'hEF, 8'hBE, 8'hAD, 8'hDE,
      8'h63, 8'h45,
      8'h76, 8'h44, 8'h33, 8'h22, 8'h11,
      8'h80, 8'h08, 8'h07, 8'h06, 8'h05,
      8'h90, 8'hA0, 8'h6F,
      8'h27, 8'h12, 8'hC0, 8'h64, 8'h00, 8'h91 };
    for (int i = 0; i < 39; i++) put(i, img[i]);
    put(250, 8'h30); put(251, 8'hF1); put(252, 8'h01);
    put(253, 8'h02); put(254, 8'h03); put(255, 8'h04);
  endtask

  task automatic t_short_forms;
    expect_all("halt R6", 32'd0, 4'h0, 4'h0, 4'hF, 4'hF, 32'h0, 32'd1, 2'd1);
    expect_all("nop", 32'd1, 4'h1, 4'h0, 4'hF, 4'hF, 32'h0, 32'd2, 2'd0);
    expect_all("ret", 32'd30, 4'h9, 4'h0, 4'hF, 4'hF, 32'h0, 32'd31, 2'd0);
  endtask

  task automatic t_reg_forms;
    expect_all("rrmov R3", 32'd2, 4'h2, 4'h0, 4'h1, 4'h2, 32'h0, 32'd4, 2'd0);
    expect_all("cmov", 32'd4, 4'h2, 4'h5, 4'hA, 4'hB, 32'h0, 32'd6, 2'd0);
    expect_all("alu", 32'd18, 4'h6, 4'h3, 4'h4, 4'h5, 32'h0, 32'd20, 2'd0);
    expect_all("push", 32'd31, 4'hA, 4'h0, 4'h6, 4'hF, 32'h0, 32'd33, 2'd0);
  endtask

  task automatic t_const_forms;
    expect_all("irmov R4", 32'd6, 4'h3, 4'h0, 4'hF, 4'h3, 32'h12345678, 32'd12, 2'd0);
    expect_all("rmmov R4", 32'd12, 4'h4, 4'h0, 4'h1, 4'h5, 32'hDEADBEEF, 32'd18, 2'd0);
    expect_all("jump R5", 32'd20, 4'h7, 4'h6, 4'hF, 4'hF, 32'h11223344, 32'd25, 2'd0);
    expect_all("call R5", 32'd25, 4'h8, 4'h0, 4'hF, 4'hF, 32'h05060708, 32'd30, 2'd0);
  endtask

  task automatic t_illegal;
    expect_all("R7 cmov fn7", 32'd33, 4'h2, 4'h7, 4'h1, 4'h2, 32'h0, 32'd35, 2'd3);
    expect_all("R7 op C", 32'd35, 4'hC, 4'h0, 4'hF, 4'hF, 32'h0, 32'd36, 2'd3);
    expect_all("R7 alu fn4", 32'd36, 4'h6, 4'h4, 4'h0, 4'h0, 32'h0, 32'd38, 2'd3);
    expect_all("R7 ret fn1", 32'd38, 4'h9, 4'h1, 4'hF, 4'hF, 32'h0, 32'd39, 2'd3);
  endtask

  task automatic t_bad_address;
    expect_all("R8 ends at last byte", 32'd250, 4'h3, 4'h0, 4'hF, 4'h1,
               32'h04030201, 32'd256, 2'd0);
    put(252, 8'h30); put(253, 8'hF1); put(254, 8'hAA); put(255, 8'h27);
    fetch(32'd252);
    chk("R8 crosses end", "status", 32'(status), 32'd2);
    fetch(32'd255);
    chk("R8 over illegal", "status", 32'(status), 32'd2);
    fetch(32'd256);
    chk("R8 over halt", "status", 32'(status), 32'd2);
    fetch(32'h1000_0000);
    chk("R8 far address", "status", 32'(status), 32'd2);
  endtask

  task automatic t_load_overwrite;
    put(38, 8'h10);
    expect_all("R9 rewrite", 32'd38, 4'h1, 4'h0, 4'hF, 4'hF, 32'h0, 32'd39, 2'd0);
  endtask

  task automatic t_idle;
    fetch(32'd1);
    @(negedge clk);
    chk("R1 idle", "out_valid", 32'(out_valid), 32'd0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    fetch_req = 1'b0; fetch_pc = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_preload;
    t_short_forms;
    t_reg_forms;
    t_const_forms;
    t_illegal;
    t_bad_address;
    t_load_overwrite;
    t_idle;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule